// File: doc/BRIEF.md
# Interval Window Self-Test Checker

This block is a self-test sequencer for a timing source whose outputs cannot be read back. It times the gap between two rising edges of an event line, or between the start command and one rising edge. The event can be a frame flyback pulse or a DMA-complete flag. The gap is measured with a loadable down counter that steps at 2 MHz. The measured time, in microseconds, is then compared against a pass window that software sets. Two hard stops end a measurement that takes too long: the counter running past zero (the ceiling), and a separate long-wait counter that runs on the system clock.

In flyback mode, a pass on the reference clock starts a retry phase. The block raises a clock-select output to the alternate source and runs the measurement again, up to `ALT_TRIES` times. It stops at the first pass. The result word gives the attempt index in its upper field and the measured microseconds in its lower field.

The controller has six states:
- `ST_IDLE`: waits for `start`. On `start`, it goes to `ST_SYNC` in flyback mode or to `ST_MEAS` in DMA mode.
- `ST_SYNC`: waits for a rising edge. An edge loads the timer and goes to `ST_MEAS`. A long-wait expiry goes to `ST_DONE`.
- `ST_MEAS`: an edge latches the count and goes to `ST_EVAL`. Underflow or long-wait expiry goes to `ST_DONE`.
- `ST_EVAL`: goes to `ST_SWITCH` after a reference pass in flyback mode. It goes back to `ST_SYNC` after an alternate window miss when tries remain. Otherwise it goes to `ST_DONE`.
- `ST_SWITCH`: selects the alternate clock and goes to `ST_SYNC`.
- `ST_DONE`: pulses `done` and goes to `ST_IDLE`.

Top module: `iw_window_checker`

## Requirements
- R1: After reset, `done`, `pass` and `alt_clk_sel` are 0 and `result` is 0.
- R2: In flyback mode (`mode`=0), the first rising edge after `start` only synchronises. The down counter is then loaded with `FLY_CEIL` (default 64000) and steps once per 0.5 us. The next rising edge latches the count, and `result[19:0]` = (load − latched) >> 1 µs.
- R3: A measurement passes only when its time t satisfies `win_lo` < t < `win_lo`+`win_span`. Both limits are exclusive.
- R4: In DMA mode (`mode`=1), timing starts at the `start` command. The counter is loaded with `DMA_CEIL` (default 40000), and timing ends at the first rising edge of `event_in`.
- R5: If the counter passes zero before the ending edge, the run ends at once with `pass`=0 and `result[19:0]`=0.
- R6: A long-wait counter is restarted at each wait. Its limit is `FLY_WAIT` clocks in flyback mode and `DMA_WAIT` clocks in DMA mode. When it expires, the run ends with `pass`=0 and `result[19:0]`=0, and no retry follows.
- R7: After a flyback pass on the reference clock, `alt_clk_sel` rises and the measurement is repeated, with the attempt index counting 1, 2, … up to `ALT_TRIES` (default 5). The first pass ends the run with `pass`=1 and that index in `result[31:20]`.
- R8: If every alternate attempt misses the window, the run ends with `pass`=0, `result[31:20]`=`ALT_TRIES`, and the last measured time in `result[19:0]`.
- R9: A window miss on the reference clock ends the run with `pass`=0, attempt index 0, the measured time, and `alt_clk_sel`=0.
- R10: A DMA-mode run never raises `alt_clk_sel` and never retries.
- R11: `done` is high for exactly one cycle per run. `pass`, `result` and `alt_clk_sel` hold their values from `done` until the next accepted `start`.
- R12: A `start` pulse received while a run is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start a self-test run (taken in idle only) |
| event_in | input | 1 | Event line being timed (rising edges count) |
| mode | input | 1 | 0 = flyback interval, 1 = DMA duration |
| win_lo | input | 16 | Lower window limit in µs (exclusive) |
| win_span | input | 16 | Window width in µs; upper limit is win_lo+win_span (exclusive) |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Final verdict |
| alt_clk_sel | output | 1 | Request to run from the alternate clock source |
| result | output | 32 | [31:20] attempt index, [19:0] measured µs |

## Verification
The hardest path to reach is an alternate-clock sequence that ends partway through. The event line has to pass on the reference clock, then miss the window a chosen number of times, then pass or go silent. The bench scripts the spacing of every rising edge: each attempt is a short spacer edge for synchronising, followed by a measured gap of 8·t+2 clocks at a tick divider of 4. That gap lands exactly on t µs whatever the latency of the synchroniser. This allows exact window boundaries, early stops, exhausted retries, and a long-wait expiry in the middle of a retry to be scheduled from the ports alone.

// File: rtl/iw_pkg.sv
package iw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_MEAS,
        ST_EVAL,
        ST_SWITCH,
        ST_DONE
    } iw_state_e;

    typedef enum logic {
        MODE_FLYBACK = 1'b0,
        MODE_DMA     = 1'b1
    } iw_mode_e;
endpackage

// File: rtl/iw_tick_gen.sv
module iw_tick_gen #(
    parameter int DIV = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [PW-1:0] pre;

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pre <= '0;
        end else if (pre == PW'(DIV - 1)) begin
            pre <= '0;
        end else begin
            pre <= pre + 1'b1;
        end
    end

    assign tick = (pre == PW'(DIV - 1)) && !restart;

    AST_TICK_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick || (DIV == 1)) else $error("tick too dense"); // R2
endmodule

// File: rtl/iw_down_timer.sv
module iw_down_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          tick,
    input  logic          latch,
    output logic [CW-1:0] cnt_lat,
    output logic          under
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            under <= 1'b0;
        end else if (load) begin
            cnt   <= load_val;
            under <= 1'b0;
        end else if (tick) begin
            if (cnt == '0) begin
                under <= 1'b1;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_lat <= '0;
        end else if (latch) begin
            cnt_lat <= cnt;
        end
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (cnt == $past(cnt) || cnt == $past(cnt) - 1'b1)) else $error("count jump"); // R2
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !latch |=> $stable(cnt_lat)) else $error("latched value moved"); // R2
endmodule

// File: rtl/iw_long_wait.sv
module iw_long_wait #(
    parameter int LW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [LW-1:0] limit,
    output logic          expired
);
    logic [LW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt     <= '0;
            expired <= 1'b0;
        end else if (!expired) begin
            if (cnt >= limit - 1'b1) begin
                expired <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_EXPIRE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !restart) |=> expired) else $error("expiry dropped"); // R6
endmodule

// File: rtl/iw_window_checker.sv
module iw_window_checker
    import iw_pkg::*;
#(
    parameter int TICK_DIV  = 25,
    parameter int FLY_CEIL  = 64000,
    parameter int DMA_CEIL  = 40000,
    parameter int FLY_WAIT  = 10000000,
    parameter int DMA_WAIT  = 5000000,
    parameter int ALT_TRIES = 5,
    parameter int UW        = 16,
    parameter int TW        = 20,
    parameter int RW        = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          event_in,
    input  logic          mode,
    input  logic [UW-1:0] win_lo,
    input  logic [UW-1:0] win_span,
    output logic          done,
    output logic          pass,
    output logic          alt_clk_sel,
    output logic [RW-1:0] result
);
    localparam int CEIL_MAX = (FLY_CEIL > DMA_CEIL) ? FLY_CEIL : DMA_CEIL;
    localparam int CW       = $clog2(CEIL_MAX + 1);
    localparam int WAIT_MAX = (FLY_WAIT > DMA_WAIT) ? FLY_WAIT : DMA_WAIT;
    localparam int LW       = $clog2(WAIT_MAX + 1);
    localparam int AW       = RW - TW;

    iw_state_e     state, next;
    iw_mode_e      mode_r, mode_use;
    logic          ev_s1, ev_s2, ev_edge;
    logic          tick, tmr_load, tmr_latch, tmr_under;
    logic          wd_restart, wd_exp;
    logic [LW-1:0] wd_limit;
    logic [CW-1:0] load_val, ceil_r, cnt_lat, elapsed;
    logic [UW-1:0] meas_us, time_r;
    logic [UW:0]   win_hi;
    logic          win_ok;
    logic [AW-1:0] attempt;

    // event edge detection through a two-stage sampler
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_s1 <= 1'b0;
            ev_s2 <= 1'b0;
        end else begin
            ev_s1 <= event_in;
            ev_s2 <= ev_s1;
        end
    end
    assign ev_edge = ev_s1 && !ev_s2;

    assign mode_use  = (state == ST_IDLE) ? iw_mode_e'(mode) : mode_r;
    assign load_val  = (mode_use == MODE_DMA) ? CW'(DMA_CEIL) : CW'(FLY_CEIL);
    assign wd_limit  = (mode_use == MODE_DMA) ? LW'(DMA_WAIT) : LW'(FLY_WAIT);
    assign ceil_r    = (mode_r == MODE_DMA) ? CW'(DMA_CEIL) : CW'(FLY_CEIL);
    assign tmr_load  = (state == ST_IDLE && start && mode_use == MODE_DMA)
                    || (state == ST_SYNC && ev_edge);
    assign tmr_latch = (state == ST_MEAS) && ev_edge;
    assign wd_restart = (next != state) && (next == ST_SYNC || next == ST_MEAS);

    assign elapsed = ceil_r - cnt_lat;
    assign meas_us = UW'(elapsed >> 1);
    assign win_hi  = {1'b0, win_lo} + {1'b0, win_span};
    assign win_ok  = (meas_us > win_lo) && ({1'b0, meas_us} < win_hi);

    iw_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .restart(tmr_load), .tick(tick)
    );

    iw_down_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(load_val),
        .tick(tick), .latch(tmr_latch), .cnt_lat(cnt_lat), .under(tmr_under)
    );

    iw_long_wait #(.LW(LW)) u_wait (
        .clk(clk), .rst_n(rst_n), .restart(wd_restart), .limit(wd_limit),
        .expired(wd_exp)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= next;
    end

    // transitions
    always_comb begin
        next = state;
        unique case (state)
            ST_IDLE:   if (start) next = (mode_use == MODE_DMA) ? ST_MEAS : ST_SYNC;
            ST_SYNC:   if (ev_edge) next = ST_MEAS;
                       else if (wd_exp) next = ST_DONE;
            ST_MEAS:   if (ev_edge) next = ST_EVAL;
                       else if (tmr_under || wd_exp) next = ST_DONE;
            ST_EVAL:   if (win_ok && mode_r == MODE_FLYBACK && attempt == '0) next = ST_SWITCH;
                       else if (!win_ok && attempt != '0 && attempt < AW'(ALT_TRIES)) next = ST_SYNC;
                       else next = ST_DONE;
            ST_SWITCH: next = ST_SYNC;
            ST_DONE:   next = ST_IDLE;
            default:   next = ST_IDLE;
        endcase
    end

    // registered outputs and run context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_r      <= MODE_FLYBACK;
            attempt     <= '0;
            pass        <= 1'b0;
            time_r      <= '0;
            alt_clk_sel <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    mode_r      <= mode_use;
                    attempt     <= '0;
                    pass        <= 1'b0;
                    time_r      <= '0;
                    alt_clk_sel <= 1'b0;
                end
                ST_SYNC: if (!ev_edge && wd_exp) begin
                    pass   <= 1'b0;
                    time_r <= '0;
                end
                ST_MEAS: if (!ev_edge && (tmr_under || wd_exp)) begin
                    pass   <= 1'b0;
                    time_r <= '0;
                end
                ST_EVAL: begin
                    pass   <= win_ok;
                    time_r <= meas_us;
                    if (next == ST_SYNC) attempt <= attempt + 1'b1;
                end
                ST_SWITCH: begin
                    alt_clk_sel <= 1'b1;
                    attempt     <= AW'(1);
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    always_comb begin
        done   = (state == ST_DONE);
        result = {attempt, {(TW-UW){1'b0}}, time_r};
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done wider than a cycle"); // R11
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start) |=> ($stable(result) && $stable(pass) && $stable(alt_clk_sel)))
        else $error("outputs moved while idle"); // R11
    AST_ATTEMPT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        attempt <= AW'(ALT_TRIES)) else $error("attempt overran"); // R8
    AST_DMA_NO_ALT: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && mode_r == MODE_DMA) |-> !alt_clk_sel) else $error("dma retried"); // R10
    AST_WAIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SYNC && !ev_edge && wd_exp) |=> (done && time_r == '0 && !pass))
        else $error("long wait not reported"); // R6
    AST_UNDER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MEAS && !ev_edge && tmr_under) |=> (done && time_r == '0 && !pass))
        else $error("underflow not reported"); // R5
endmodule

// File: tb/iw_window_checker_tb.sv
module iw_window_checker_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        event_in = 1'b0;
    logic        mode = 1'b0;
    logic [15:0] win_lo = 16'd0;
    logic [15:0] win_span = 16'd0;
    logic        done, pass, alt_clk_sel;
    logic [31:0] result;

    int checks = 0, errors = 0, cyc = 0, done_cnt = 0;
    int snap = 0, t0 = 0, last_elapsed = 0;
    bit prev_done = 1'b0, model_on = 1'b0, finished = 1'b0;
    logic        exp_pass = 1'b0, exp_alt = 1'b0;
    logic [31:0] exp_result = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iw_window_checker #(
        .TICK_DIV(4), .FLY_CEIL(400), .DMA_CEIL(200),
        .FLY_WAIT(3000), .DMA_WAIT(2000), .ALT_TRIES(5)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .event_in(event_in), .mode(mode),
        .win_lo(win_lo), .win_span(win_span), .done(done), .pass(pass),
        .alt_clk_sel(alt_clk_sel), .result(result)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the reference expectations
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (done) begin
                done_cnt++;
                check("R11 done lasts one cycle", {31'b0, prev_done}, 32'd0);
            end
            if (model_on) begin
                check("R11 pass held", {31'b0, pass}, {31'b0, exp_pass});
                check("R11 result held", result, exp_result);
                check("R11 alt select held", {31'b0, alt_clk_sel}, {31'b0, exp_alt});
            end
        end
        prev_done = done;
    end

    function automatic int gap_of(int us);
        return 8 * us + 2;   // 2*us ticks of 4 clocks, centred
    endfunction

    function automatic logic [31:0] word(int att, int us);
        return (32'(att) << 20) | 32'(us);
    endfunction

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            event_in = 1'b0;
            start = 1'b0;
        end
    endtask

    task automatic gap_rise(int g);
        idle(g);
        event_in = 1'b1;
    endtask

    task automatic begin_run(logic m, int lo, int span);
        @(negedge clk);
        model_on = 1'b0;
        @(negedge clk);
        mode = m;
        win_lo = 16'(lo);
        win_span = 16'(span);
        snap = done_cnt;
        t0 = cyc;
        start = 1'b1;
    endtask

    task automatic finish_run(string tag, int limit, logic ep, int att, int us, logic ealt);
        int n = 0;
        while (done_cnt == snap && n < limit) begin
            @(negedge clk);
            event_in = 1'b0;
            start = 1'b0;
            n++;
        end
        last_elapsed = cyc - t0;
        check({tag, " done seen"}, 32'(done_cnt - snap), 32'd1);
        exp_pass = ep;
        exp_alt = ealt;
        exp_result = word(att, us);
        check({tag, " pass"}, {31'b0, pass}, {31'b0, ep});
        check({tag, " result"}, result, exp_result);
        check({tag, " alt select"}, {31'b0, alt_clk_sel}, {31'b0, ealt});
        @(negedge clk);
        model_on = 1'b1;
    endtask

    task automatic fly_attempt(int us, bit first);
        gap_rise(first ? 10 : 20);
        gap_rise(gap_of(us));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 done at reset", {31'b0, done}, 32'd0);
        check("R1 pass at reset", {31'b0, pass}, 32'd0);
        check("R1 alt at reset", {31'b0, alt_clk_sel}, 32'd0);
        check("R1 result at reset", result, 32'd0);
        rst_n = 1'b1;
        idle(5);

        // R9 / R2: reference miss above window
        begin_run(1'b0, 60, 20);
        fly_attempt(90, 1'b1);
        finish_run("R9 R2 ref miss", 200, 1'b0, 0, 90, 1'b0);

        // R3 boundaries are exclusive
        begin_run(1'b0, 60, 20);
        fly_attempt(60, 1'b1);
        finish_run("R3 lower bound", 200, 1'b0, 0, 60, 1'b0);
        begin_run(1'b0, 60, 20);
        fly_attempt(80, 1'b1);
        finish_run("R3 upper bound", 200, 1'b0, 0, 80, 1'b0);

        // R7: ref pass, alt miss, alt pass on attempt 2
        begin_run(1'b0, 60, 20);
        fly_attempt(61, 1'b1);
        fly_attempt(85, 1'b0);
        fly_attempt(79, 1'b0);
        finish_run("R7 early stop", 200, 1'b1, 2, 79, 1'b1);

        // R8: every alternate attempt misses
        begin_run(1'b0, 60, 20);
        fly_attempt(70, 1'b1);
        for (int k = 0; k < 5; k++) fly_attempt(90, 1'b0);
        finish_run("R8 tries exhausted", 200, 1'b0, 5, 90, 1'b1);

        // R4 / R10: DMA pass, no retry
        begin_run(1'b1, 40, 30);
        gap_rise(gap_of(55));
        finish_run("R4 R10 dma pass", 200, 1'b1, 0, 55, 1'b0);
        begin_run(1'b1, 40, 30);
        gap_rise(gap_of(69));
        finish_run("R3 R4 dma top inside", 200, 1'b1, 0, 69, 1'b0);
        begin_run(1'b1, 40, 30);
        gap_rise(gap_of(40));
        finish_run("R3 R4 dma at lower", 200, 1'b0, 0, 40, 1'b0);

        // R5: DMA ceiling underflow well before long wait
        begin_run(1'b1, 40, 30);
        finish_run("R5 dma underflow", 3000, 1'b0, 0, 0, 1'b0);
        check("R5 dma underflow before long wait", {31'b0, last_elapsed < 1500}, 32'd1);

        // R5: flyback ceiling underflow after sync
        begin_run(1'b0, 60, 20);
        gap_rise(10);
        finish_run("R5 fly underflow", 4000, 1'b0, 0, 0, 1'b0);
        check("R5 fly underflow before long wait", {31'b0, last_elapsed < 2500}, 32'd1);

        // R6: no sync edge at all
        begin_run(1'b0, 60, 20);
        finish_run("R6 sync wait expiry", 4000, 1'b0, 0, 0, 1'b0);
        check("R6 expiry not early", {31'b0, last_elapsed >= 2990}, 32'd1);

        // R6 / R7: long wait expires during the alternate phase, no further retry
        begin_run(1'b0, 60, 20);
        fly_attempt(70, 1'b1);
        finish_run("R6 R7 alt wait expiry", 4000, 1'b0, 1, 0, 1'b1);

        // R12: start during a DMA run has no effect
        begin_run(1'b1, 40, 30);
        idle(30);
        start = 1'b1;
        gap_rise(gap_of(55) - 30);
        finish_run("R12 busy start", 200, 1'b1, 0, 55, 1'b0);
        idle(60);
        check("R12 no extra done", 32'(done_cnt - snap), 32'd1);

        idle(10);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule